// File: doc/BRIEF.md
# External Bus Read Sequencer

This block is a bus master that performs single read transfers on an asynchronous-style external memory bus. An internal requester hands it an address and a chip-select index through a request/ready handshake. The block then walks a six-phase read transfer. It drives the halfword address, the read/write line, one active-low chip select and an active-low output enable. It waits for a transfer acknowledge, captures the 16-bit halfword present on the upper data lanes, and returns it with a one-cycle done pulse.

The block runs on a system clock at twice the bus clock rate. Each system cycle is one half of a bus clock period. The bus clock is generated inside the block and driven out, so that "rising" and "falling" bus clock edges are simply alternate system clock edges. Each chip select is configured for one of two kinds of termination. With internal termination, a 4-bit wait count generates the acknowledge inside the block and the external acknowledge pin is ignored. With external termination, the device drives an active-low acknowledge, and a 4-bit timeout ends a transfer that never receives it, with an error flag.

Top module: `xbus_rd_master`

## Requirements
- R1: After synchronous reset all chip selects and the output enable are high (inactive), the read/write line is high, the generated bus clock is low and done is low.
- R2: `rq_ready_o` is high only while no transfer is in progress (or in the final phase of one) and the bus clock is low; it is low during the address, strobe and wait phases.
- R3: On the system edge that accepts a request, the bus clock goes high and the address (halfword address, bit 0 not driven) appears on `bus_addr_o` with read/write high. The address stays stable for as long as the output enable is low.
- R4: One system cycle after the address phase, the selected chip select (bit index = `rq_cs_i`) and the output enable go low while the bus clock is low; all other chip selects stay high.
- R5: With internal termination (`cfg_ext_i` bit = 0) and wait count W from `cfg_wait_i[4*i+3:4*i]`, done is high exactly 5+2W system cycles after the accepting edge, whatever `bus_ta_n_i` does.
- R6: With external termination (`cfg_ext_i` bit = 1), the acknowledge is sampled at the end of each low bus-clock sampling phase. Each sample found high inserts one wait state, and a sample found low ends the transfer. The returned data are the upper lanes `bus_dhi_i` captured on that edge.
- R7: Chip select and output enable return high on the edge after data capture, so they are already high in the cycle where done is asserted and in the next address phase.
- R8: With external termination and no acknowledge, the transfer ends after 16 samples (15 wait states, done at 35 system cycles) with `rd_err_o` = 1 and `rd_data_o` = 0.
- R9: An acknowledge found low on the 16th sample wins over the timeout: done at 35 cycles, no error, valid data.
- R10: A request presented in the done cycle is accepted on the next edge, and its address phase begins immediately without an idle cycle.
- R11: Done is a single-cycle pulse, and `rd_err_o` is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_valid_i | input | 1 | Read request present |
| rq_ready_o | output | 1 | Request will be accepted on this edge |
| rq_addr_i | input | ADDR_W (23) | Halfword address (external A23..A1) |
| rq_cs_i | input | CS_W (1) | Index of the chip select to use |
| cfg_ext_i | input | NUM_CS (2) | Per chip select: 1 = external acknowledge, 0 = internal wait count |
| cfg_wait_i | input | NUM_CS*4 (8) | Per chip select 4-bit wait count, chip select i in bits 4i+3..4i |
| rd_done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 16 | Captured read halfword |
| rd_err_o | output | 1 | Completion was a timeout |
| bus_clk_o | output | 1 | Generated bus clock |
| bus_addr_o | output | ADDR_W (23) | External address lines A23..A1 |
| bus_rw_o | output | 1 | Read/write, high for read |
| bus_cs_n_o | output | NUM_CS (2) | Active-low chip selects |
| bus_oe_n_o | output | 1 | Active-low output enable |
| bus_ta_n_i | input | 1 | Active-low transfer acknowledge from the device |
| bus_dhi_i | input | 16 | Upper data lanes D31..D16 |

## Verification
Two functions can meet in one sampling edge. In the first, the device acknowledge arrives on exactly the 16th sample, where the timeout would otherwise end the transfer. The bench's device model is set to that delay, and the completion must carry valid data with no error flag after 35 cycles. In the second, completion and acceptance meet: a new request is offered in the done cycle, and the next cycle must already show the new address with the bus clock high and every chip select released.

// File: rtl/xbus_rd_pkg.sv
// Package xbus_rd_pkg
// Shared phase encoding for the external bus read sequencer.
// Assumes one system clock cycle equals one half bus clock period.
package xbus_rd_pkg;

    // Transfer phases: P0 address, P1 strobe, P2/P3 sample pair, P4 capture hold, P5 release/done
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_P0   = 3'd1,
        PH_P1   = 3'd2,
        PH_P2   = 3'd3,
        PH_P3   = 3'd4,
        PH_P4   = 3'd5,
        PH_P5   = 3'd6
    } xbus_phase_e;

endpackage

// File: rtl/xbus_rd_seq.sv
// Module xbus_rd_seq
// Phase sequencer and bus clock generator. The bus clock toggles on every
// system edge. A request is taken only while the bus clock is low, so the
// address phase always starts with the bus clock high. The P3 -> P2 loop
// forms one wait state per bus clock period.
// Assumes fin_i is only meaningful in phase P3.
module xbus_rd_seq
    import xbus_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic        fin_i,
    output xbus_phase_e phase_o,
    output logic        bclk_o,
    output logic        ready_o
);

    xbus_phase_e phase_q;
    xbus_phase_e phase_d;
    logic        bclk_q;

    // Bus clock divider: toggles each system cycle, low out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= ~bclk_q;
    end

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (take_i) phase_d = PH_P0;
            PH_P0:   phase_d = PH_P1;
            PH_P1:   phase_d = PH_P2;
            PH_P2:   phase_d = PH_P3;
            PH_P3:   phase_d = fin_i ? PH_P4 : PH_P2;
            PH_P4:   phase_d = PH_P5;
            PH_P5:   phase_d = take_i ? PH_P0 : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Ready when free (or finishing) and the next edge is a rising bus edge
    always_comb begin
        ready_o = ((phase_q == PH_IDLE) || (phase_q == PH_P5)) && !bclk_q;
    end

    assign phase_o = phase_q;
    assign bclk_o  = bclk_q;

    AST_ADDR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_P0) |-> bclk_q); // R3

    AST_WAIT_ONLY_UNFINISHED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_P2 && $past(phase_q) == PH_P3) |-> !$past(fin_i)); // R6

endmodule

// File: rtl/xbus_rd_term.sv
// Module xbus_rd_term
// Termination unit. Latches the selected chip select's termination kind and
// wait count when a request is taken. In each sampling phase P3 it decides
// whether the transfer ends: internally when the wait count is spent, or
// externally when the acknowledge is low or the timeout is reached.
// Assumes bus_ta_n_i is synchronous to clk.
module xbus_rd_term
    import xbus_rd_pkg::*;
#(
    parameter int WS_W  = 4,
    parameter int TMO_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            sel_ext_i,
    input  logic [WS_W-1:0] sel_wait_i,
    input  xbus_phase_e     phase_i,
    input  logic            ta_n_i,
    output logic            fin_o,
    output logic            tmo_o
);

    localparam logic [TMO_W-1:0] TMO_LAST = {TMO_W{1'b1}};

    logic             ext_q;
    logic [WS_W-1:0]  wcnt_q;
    logic [TMO_W-1:0] tcnt_q;
    logic             sampling;

    assign sampling = (phase_i == PH_P3);

    // End-of-transfer decision for the current sampling phase
    always_comb begin
        fin_o = 1'b0;
        tmo_o = 1'b0;
        if (sampling) begin
            if (ext_q) begin
                fin_o = !ta_n_i || (tcnt_q == TMO_LAST);
                tmo_o = ta_n_i && (tcnt_q == TMO_LAST);
            end else begin
                fin_o = (wcnt_q == '0);
            end
        end
    end

    // Counters: load on accept, step once per unfinished sampling phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            wcnt_q <= '0;
            tcnt_q <= '0;
        end else if (take_i) begin
            ext_q  <= sel_ext_i;
            wcnt_q <= sel_wait_i;
            tcnt_q <= '0;
        end else if (sampling && !fin_o) begin
            if (ext_q) tcnt_q <= tcnt_q + 1'b1;
            else       wcnt_q <= wcnt_q - 1'b1;
        end
    end

    AST_TMO_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && ext_q && tcnt_q == TMO_LAST) |-> fin_o); // R8

    AST_WAIT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && !ext_q && !fin_o) |=> (wcnt_q != {WS_W{1'b1}})); // R5

endmodule

// File: rtl/xbus_rd_bus.sv
// Module xbus_rd_bus
// Bus-side datapath: address and chip-select index registers, strobe
// registers, read data capture and error flag. Strobes fall on the edge
// that leaves P0 (a falling bus edge) and rise on the edge that leaves P4.
// Assumes the phase input follows xbus_rd_seq's ordering.
module xbus_rd_bus
    import xbus_rd_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CS_W-1:0]   cs_i,
    input  xbus_phase_e       phase_i,
    input  logic              fin_i,
    input  logic              tmo_i,
    input  logic [DW-1:0]     dhi_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rw_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              oe_n_o,
    output logic [DW-1:0]     data_o,
    output logic              err_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   csix_q;
    logic              rw_q;
    logic              oe_n_q;
    logic [NUM_CS-1:0] cs_n_q;
    logic [DW-1:0]     data_q;
    logic              err_q;
    logic              strobe_on;
    logic              strobe_off;

    assign strobe_on  = (phase_i == PH_P0);
    assign strobe_off = (phase_i == PH_P4);

    // Address, chip-select index and read/write: loaded on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            csix_q <= '0;
            rw_q   <= 1'b1;
        end else if (take_i) begin
            addr_q <= addr_i;
            csix_q <= cs_i;
            rw_q   <= 1'b1;
        end
    end

    // Output enable strobe
    always_ff @(posedge clk) begin
        if (!rst_n)          oe_n_q <= 1'b1;
        else if (strobe_on)  oe_n_q <= 1'b0;
        else if (strobe_off) oe_n_q <= 1'b1;
    end

    // One strobe register per chip select
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        always_ff @(posedge clk) begin
            if (!rst_n)
                cs_n_q[i] <= 1'b1;
            else if (strobe_on && (csix_q == CS_W'(i)))
                cs_n_q[i] <= 1'b0;
            else if (strobe_off)
                cs_n_q[i] <= 1'b1;
        end
    end

    // Data capture and error flag on the finishing sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= 1'b0;
        end else if (fin_i) begin
            data_q <= tmo_i ? '0 : dhi_i;
            err_q  <= tmo_i;
        end
    end

    assign addr_o = addr_q;
    assign rw_o   = rw_q;
    assign cs_n_o = cs_n_q;
    assign oe_n_o = oe_n_q;
    assign data_o = data_q;
    assign err_o  = err_q;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_q)); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_q && $past(!oe_n_q)) |-> $stable(addr_q)); // R3

    AST_STROBES_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_P5) |-> (oe_n_q && (&cs_n_q))); // R7

endmodule

// File: rtl/xbus_rd_master.sv
// Module xbus_rd_master
// Top of the external bus read sequencer. Connects the phase sequencer,
// the termination unit and the bus datapath, and picks the per chip-select
// configuration for the incoming request.
// Assumes all inputs are synchronous to clk.
module xbus_rd_master
    import xbus_rd_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int NUM_CS = 2,
    parameter int WS_W   = 4,
    parameter int TMO_W  = 4,
    parameter int DW     = 16,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rq_valid_i,
    output logic                   rq_ready_o,
    input  logic [ADDR_W-1:0]      rq_addr_i,
    input  logic [CS_W-1:0]        rq_cs_i,
    input  logic [NUM_CS-1:0]      cfg_ext_i,
    input  logic [NUM_CS*WS_W-1:0] cfg_wait_i,
    output logic                   rd_done_o,
    output logic [DW-1:0]          rd_data_o,
    output logic                   rd_err_o,
    output logic                   bus_clk_o,
    output logic [ADDR_W-1:0]      bus_addr_o,
    output logic                   bus_rw_o,
    output logic [NUM_CS-1:0]      bus_cs_n_o,
    output logic                   bus_oe_n_o,
    input  logic                   bus_ta_n_i,
    input  logic [DW-1:0]          bus_dhi_i
);

    xbus_phase_e     phase;
    logic            ready;
    logic            take;
    logic            fin;
    logic            tmo;
    logic            sel_ext;
    logic [WS_W-1:0] sel_wait;
    logic            err_q;

    assign take = rq_valid_i && ready;

    // Per chip-select configuration lookup for the offered request
    always_comb begin
        sel_ext  = cfg_ext_i[rq_cs_i];
        sel_wait = cfg_wait_i[rq_cs_i*WS_W +: WS_W];
    end

    xbus_rd_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .fin_i   (fin),
        .phase_o (phase),
        .bclk_o  (bus_clk_o),
        .ready_o (ready)
    );

    xbus_rd_term #(.WS_W(WS_W), .TMO_W(TMO_W)) u_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .sel_ext_i  (sel_ext),
        .sel_wait_i (sel_wait),
        .phase_i    (phase),
        .ta_n_i     (bus_ta_n_i),
        .fin_o      (fin),
        .tmo_o      (tmo)
    );

    xbus_rd_bus #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_W(CS_W), .DW(DW)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .addr_i  (rq_addr_i),
        .cs_i    (rq_cs_i),
        .phase_i (phase),
        .fin_i   (fin),
        .tmo_i   (tmo),
        .dhi_i   (bus_dhi_i),
        .addr_o  (bus_addr_o),
        .rw_o    (bus_rw_o),
        .cs_n_o  (bus_cs_n_o),
        .oe_n_o  (bus_oe_n_o),
        .data_o  (rd_data_o),
        .err_o   (err_q)
    );

    // Done pulse during the release phase; error qualified by it
    always_comb begin
        rq_ready_o = ready;
        rd_done_o  = (phase == PH_P5);
        rd_err_o   = rd_done_o && err_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> !rd_done_o); // R11

    AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe_n_o) |-> !bus_clk_o); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n_o) |-> !rq_ready_o); // R2

endmodule

// File: tb/sim_xbus_rd_master.sv
// Directed bench for xbus_rd_master with a behavioural external device.
module sim_xbus_rd_master;

    localparam int AW = 23;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rq_valid = 1'b0;
    logic          rq_ready;
    logic [AW-1:0] rq_addr = '0;
    logic [0:0]    rq_cs = '0;
    logic [NC-1:0] cfg_ext = 2'b10;
    logic [7:0]    cfg_wait = 8'h00;
    logic          done;
    logic [15:0]   rdata;
    logic          rerr;
    logic          bclk;
    logic [AW-1:0] baddr;
    logic          brw;
    logic [NC-1:0] bcs_n;
    logic          boe_n;
    logic          bta_n;
    logic [15:0]   bdhi;

    int errors = 0;
    int checks = 0;

    // Device model controls
    logic       dev_ta_en = 1'b0;
    int         dev_d = 0;
    logic [7:0] dev_cnt;

    always #10 clk = ~clk;

    xbus_rd_master u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rq_valid_i (rq_valid),
        .rq_ready_o (rq_ready),
        .rq_addr_i  (rq_addr),
        .rq_cs_i    (rq_cs),
        .cfg_ext_i  (cfg_ext),
        .cfg_wait_i (cfg_wait),
        .rd_done_o  (done),
        .rd_data_o  (rdata),
        .rd_err_o   (rerr),
        .bus_clk_o  (bclk),
        .bus_addr_o (baddr),
        .bus_rw_o   (brw),
        .bus_cs_n_o (bcs_n),
        .bus_oe_n_o (boe_n),
        .bus_ta_n_i (bta_n),
        .bus_dhi_i  (bdhi)
    );

    // Device: counts cycles with a chip select low, acks after dev_d wait states
    always_ff @(posedge clk) begin
        if (&bcs_n) dev_cnt <= 8'd0;
        else        dev_cnt <= dev_cnt + 8'd1;
    end
    assign bta_n = !(dev_ta_en && (&bcs_n == 1'b0) &&
                     ((int'(dev_cnt) == 2*dev_d + 1) || (int'(dev_cnt) == 2*dev_d + 2)));
    assign bdhi  = (&bcs_n) ? 16'h0000 : (baddr[15:0] ^ 16'h5A5A);

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer a request and return just after the accepting edge
    task automatic launch(input logic [0:0] cs, input logic [AW-1:0] a);
        while (!rq_ready) @(negedge clk);
        rq_cs    = cs;
        rq_addr  = a;
        rq_valid = 1'b1;
        @(posedge clk);
        #1 rq_valid = 1'b0;
    endtask

    // Follow one transfer to its done cycle; returns at that negedge
    task automatic observe(input logic [0:0] cs, input logic [AW-1:0] a, input int exp_n,
                           input logic exp_err, input logic [15:0] exp_data, input string req);
        int  n;
        int  addr_bad;
        addr_bad = 0;
        n = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk(bclk == 1'b1, "R3 bus clock high in address phase", bclk, 1);
                chk(baddr == a, "R3 address driven", baddr, a);
                chk(brw == 1'b1, "R3 read/write high", brw, 1);
                chk(&bcs_n && boe_n, "R7 strobes high in address phase", {bcs_n, boe_n}, 3'b111);
                chk(!done && !rerr, "R11 no done or error in address phase", {done, rerr}, 0);
            end
            if (k == 1) begin
                chk(bcs_n == ~(2'b01 << cs), "R4 selected chip select only", bcs_n, ~(2'b01 << cs));
                chk(!boe_n && !bclk, "R4 output enable low on low bus clock", {boe_n, bclk}, 0);
            end
            if (k == 2 || k == 3)
                chk(!rq_ready, "R2 not ready while busy", rq_ready, 0);
            if (!boe_n && baddr != a) addr_bad++;
            if (done) begin
                n = k;
                break;
            end
        end
        chk(addr_bad == 0, "R3 address stable while strobed", addr_bad, 0);
        chk(n == exp_n, {req, " done cycle"}, n, exp_n);
        chk(rerr == exp_err, {req, " error flag"}, rerr, exp_err);
        chk(rdata == exp_data, {req, " read data"}, rdata, exp_data);
        chk(&bcs_n && boe_n, "R7 strobes released at done", {bcs_n, boe_n}, 3'b111);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(&bcs_n && boe_n, "R1 strobes inactive after reset", {bcs_n, boe_n}, 3'b111);
        chk(brw == 1'b1 && !done, "R1 rw high, no done", {brw, done}, 2'b10);
        rst_n = 1'b1;
    endtask

    task automatic t_internal(input int w, input logic ta_noise, input logic [AW-1:0] a);
        cfg_wait  = {4'd0, 4'(w)};
        dev_ta_en = ta_noise;
        dev_d     = 0;
        launch(1'b0, a);
        observe(1'b0, a, 5 + 2*w, 1'b0, a[15:0] ^ 16'h5A5A, "R5 internal");
    endtask

    task automatic t_external(input int d, input logic [AW-1:0] a);
        dev_ta_en = 1'b1;
        dev_d     = d;
        launch(1'b1, a);
        observe(1'b1, a, 5 + 2*d, 1'b0, a[15:0] ^ 16'h5A5A, "R6 external");
    endtask

    task automatic t_timeout(input logic [AW-1:0] a);
        dev_ta_en = 1'b0;
        launch(1'b1, a);
        observe(1'b1, a, 35, 1'b1, 16'h0000, "R8 timeout");
    endtask

    task automatic t_race(input logic [AW-1:0] a);
        dev_ta_en = 1'b1;
        dev_d     = 15;
        launch(1'b1, a);
        observe(1'b1, a, 35, 1'b0, a[15:0] ^ 16'h5A5A, "R9 ack on last sample");
    endtask

    task automatic t_back2back(input logic [AW-1:0] a1, input logic [AW-1:0] a2);
        cfg_wait  = 8'h01;
        dev_ta_en = 1'b1;
        dev_d     = 2;
        launch(1'b0, a1);
        observe(1'b0, a1, 7, 1'b0, a1[15:0] ^ 16'h5A5A, "R10 first transfer");
        chk(rq_ready == 1'b1, "R10 ready in done cycle", rq_ready, 1);
        launch(1'b1, a2);
        observe(1'b1, a2, 9, 1'b0, a2[15:0] ^ 16'h5A5A, "R10 chained transfer");
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        repeat (3) @(negedge clk);
        t_internal(0, 1'b0, 23'h012345);
        t_internal(3, 1'b1, 23'h7FFFFF);
        t_external(0, 23'h00A5C3);
        t_external(4, 23'h3C0F0F);
        t_timeout(23'h111111);
        t_race(23'h2468AC);
        t_back2back(23'h000001, 23'h40ABCD);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule